// File: doc/BRIEF.md
# Vector Scatter-Accumulate Staging Buffer

This block collects the element writes of one vector scatter-accumulate operation into a byte-wide staging log. It then commits that log to a local scratch memory by adding each staged element into the memory contents. The log holds one vector of byte slots, 128 by default. Each slot keeps a data byte, the full target address of that byte and one valid bit. A log write delivers one element of 2 or 4 bytes. It carries a base address, an element index, a length bound, a predicate-enable flag and a per-lane predicate vector.

An operation is opened with a start pulse that fixes the element size used at commit. A later commit pulse makes the block walk the slots in steps of that size. For every element whose first slot is valid, the block reads the memory bytes at the logged addresses and assembles them little-endian. It adds the logged increment modulo the element width and writes the sum back byte by byte. The memory port is a single byte-wide port with one cycle of read latency. While the walk runs, busy is high and log writes are dropped. A one-cycle done pulse ends the operation, and all valid bits are left clear.

Top module: `scatter_accum_stage`

## Requirements
- R1: After reset, busy, done and mem_en are low and no slot is valid, so a commit that follows without any log writes produces no memory access.
- R2: A log write with element index k and size S (2 when log_wide is 0, 4 when it is 1) puts byte i (log_data bits 8i+7..8i) and address log_addr+i into slot S*k+i. Bytes whose slot lies at or beyond the vector size are dropped.
- R3: Byte i of a logged element is marked valid only when log_addr+i is less than or equal to log_addr+log_len, both sums taken modulo 2^AW. Its data and address are written in either case.
- R4: With log_pred_en high, byte i additionally needs log_pred bit S*k+i to be 1 to be valid. With log_pred_en low, the predicate vector has no effect.
- R5: A commit walks slots 0, S, 2S, ... with S taken from op_wide at start. An element is read and written only when the valid bit of its first slot is set. Elements with a clear first slot cause no memory access, even when their later slots are valid.
- R6: A processed element reads its S bytes in ascending slot order, forms the little-endian value, adds the little-endian increment modulo 2^(8S), and writes the S result bytes back to the same addresses in ascending slot order. Elements are processed in slot order, so overlapping addresses accumulate.
- R7: Each read is followed by a cycle with mem_en low before the next access, which gives the read data its one cycle of latency.
- R8: When a commit ends, every valid bit is clear, and a further commit with no new log writes makes no memory access.
- R9: op_start (taken only while idle) arms one operation. A commit pulse while idle and armed raises busy on the next cycle. A commit while not armed is ignored. done is high for exactly one cycle at the end, after which busy is low and the operation is disarmed.
- R10: Log writes presented while busy is high leave the staging log unchanged.
- R11: While idle, clr clears every valid bit, and a log write in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear all valid bits while idle |
| log_valid | input | 1 | Log one element this cycle |
| log_addr | input | AW | Byte address of element byte 0 |
| log_idx | input | log2(VBYTES/2) | Element index |
| log_wide | input | 1 | Element size of the log write: 0 = 2 bytes, 1 = 4 bytes |
| log_len | input | AW | Length bound added to the base address |
| log_pred_en | input | 1 | Apply per-lane predicate |
| log_pred | input | VBYTES | One predicate bit per byte lane |
| log_data | input | 32 | Increment bytes, little-endian |
| op_start | input | 1 | Arm an operation |
| op_wide | input | 1 | Commit element size: 0 = 2 bytes, 1 = 4 bytes |
| commit | input | 1 | Begin commit of the armed operation |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle end-of-commit pulse |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid one cycle after a read |

## Verification
The bench targets elements whose first byte is invalid while later bytes are valid. Two cases produce this: an address sum that wraps past the length bound, and a predicate lane at zero. A design that tested any byte, rather than the first, would then touch memory. It also logs with one size and commits with the other. Under that mismatch, a design that used the log-time size for the walk would update the wrong addresses. Carries across byte boundaries, all-ones increments and two elements aimed at one address are checked. These expose a wrong byte order, a missing wraparound, or reads issued ahead of the previous element's writes. Log writes during a commit, a clear before commit, and a commit without start are included as well. Each would show up as a stray write if the design accepted them.

// File: rtl/scatter_accum_stage.sv
`timescale 1ns/1ps
module scatter_accum_stage #(
  parameter int VBYTES = 128,
  parameter int AW = 32,
  localparam int IW = $clog2(VBYTES/2)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              log_valid,
  input  logic [AW-1:0]     log_addr,
  input  logic [IW-1:0]     log_idx,
  input  logic              log_wide,
  input  logic [AW-1:0]     log_len,
  input  logic              log_pred_en,
  input  logic [VBYTES-1:0] log_pred,
  input  logic [31:0]       log_data,
  input  logic              op_start,
  input  logic              op_wide,
  input  logic              commit,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int VI = $clog2(VBYTES);
  localparam int EW = VI + 1;
  localparam int SW = VI + 2;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD, S_CAP, S_ADD, S_WR, S_NXT, S_FIN} st_t;

  st_t                      st;
  logic [VBYTES-1:0]        mk_q;
  logic [VBYTES-1:0][7:0]   dt_q;
  logic [VBYTES-1:0][AW-1:0] sa_q;
  logic                     pend_q, wide_q;
  logic [EW-1:0]            ep;
  logic [1:0]               bc;
  logic [31:0]              acc, inc;

  logic [SW-1:0] l_slot [4];
  logic          l_ok   [4];
  logic          l_mk   [4];

  wire [1:0]    last  = wide_q ? 2'd3 : 2'd1;
  wire [VI-1:0] cslot = ep[VI-1:0] + VI'(bc);
  wire [EW-1:0] nep   = ep + (wide_q ? EW'(4) : EW'(2));
  wire          log_we = log_valid && !busy && !clr;
  wire          go     = !busy && commit && pend_q;

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_en    = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = sa_q[cslot];
  assign mem_wdata = acc[{bc, 3'b000} +: 8];

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      l_slot[i] = (log_wide ? SW'({log_idx, 2'b00}) : SW'({log_idx, 1'b0})) + SW'(i);
      l_ok[i]   = (i < 2 || log_wide) && (l_slot[i] < SW'(VBYTES));
      l_mk[i]   = (AW'(log_addr + AW'(i)) <= AW'(log_addr + log_len)) &&
                  (!log_pred_en || log_pred[l_slot[i][VI-1:0]]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mk_q   <= '0;
      dt_q   <= '0;
      sa_q   <= '0;
      pend_q <= 1'b0;
      wide_q <= 1'b0;
      ep     <= '0;
      bc     <= '0;
      acc    <= '0;
      inc    <= '0;
    end else begin
      if (!busy && clr) mk_q <= '0;
      if (log_we) begin
        for (int i = 0; i < 4; i++) begin
          if (l_ok[i]) begin
            dt_q[l_slot[i][VI-1:0]] <= log_data[8*i +: 8];
            sa_q[l_slot[i][VI-1:0]] <= AW'(log_addr + AW'(i));
            mk_q[l_slot[i][VI-1:0]] <= l_mk[i];
          end
        end
      end
      if (!busy && op_start) begin
        pend_q <= 1'b1;
        wide_q <= op_wide;
      end
      case (st)
        S_IDLE: if (go) begin
          ep <= '0;
          st <= S_CHK;
        end
        S_CHK: begin
          acc <= '0;
          inc <= '0;
          bc  <= '0;
          st  <= mk_q[ep[VI-1:0]] ? S_RD : S_NXT;
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          acc[{bc, 3'b000} +: 8] <= mem_rdata;
          inc[{bc, 3'b000} +: 8] <= dt_q[cslot];
          if (bc == last) begin
            bc <= '0;
            st <= S_ADD;
          end else begin
            bc <= bc + 2'd1;
            st <= S_RD;
          end
        end
        S_ADD: begin
          acc <= acc + inc;
          st  <= S_WR;
        end
        S_WR: begin
          mk_q[cslot] <= 1'b0;
          dt_q[cslot] <= '0;
          if (bc == last) st <= S_NXT;
          else bc <= bc + 2'd1;
        end
        S_NXT: begin
          if (nep >= EW'(VBYTES)) st <= S_FIN;
          else begin
            ep <= nep;
            st <= S_CHK;
          end
        end
        S_FIN: begin
          mk_q   <= '0;
          pend_q <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_read_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> !mem_en);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_commit_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit && pend_q) |=> busy);
  p_cleared_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mk_q == '0));
  p_log_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sa_q));
endmodule

// File: tb/tb_scatter_accum_stage.sv
`timescale 1ns/1ps
module tb_scatter_accum_stage;
  localparam int VB = 128;
  localparam int AW = 10;
  localparam int MS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic clr = 0, log_valid = 0, log_wide = 0, log_pred_en = 0;
  logic op_start = 0, op_wide = 0, commit = 0;
  logic [AW-1:0] log_addr = '0, log_len = '0;
  logic [5:0] log_idx = '0;
  logic [VB-1:0] log_pred = '0;
  logic [31:0] log_data = '0;
  logic busy, done, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;

  scatter_accum_stage #(.VBYTES(VB), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .log_valid(log_valid), .log_addr(log_addr),
    .log_idx(log_idx), .log_wide(log_wide), .log_len(log_len), .log_pred_en(log_pred_en),
    .log_pred(log_pred), .log_data(log_data), .op_start(op_start), .op_wide(op_wide),
    .commit(commit), .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  bit [7:0] mem [MS];
  bit [7:0] emem [MS];
  bit [7:0] md [VB];
  int       ma [VB];
  bit       mm [VB];
  int qa[$], qd[$];
  string qt[$];
  int n_chk = 0, n_fail = 0, rd_seen = 0, wr_seen = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    int a, d;
    string t;
    if (rst_n && mem_en) begin
      if (mem_we) begin
        wr_seen++;
        if (qa.size() == 0) chk(0, "R5 unexpected write", int'(mem_addr), -1);
        else begin
          a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
          chk(int'(mem_addr) == a, {t, " write address"}, int'(mem_addr), a);
          chk(int'(mem_wdata) == d, {t, " write data"}, int'(mem_wdata), d);
        end
      end else rd_seen++;
    end
  end

  task automatic log_elem(int a, int idx, bit wide, int len, bit pen,
                          logic [VB-1:0] pred, logic [31:0] d, bit take);
    int s = wide ? 4 : 2;
    log_valid = 1; log_addr = AW'(a); log_idx = 6'(idx); log_wide = wide;
    log_len = AW'(len); log_pred_en = pen; log_pred = pred; log_data = d;
    @(negedge clk);
    log_valid = 0;
    if (take) for (int i = 0; i < s; i++) begin
      int sl = idx * s + i;
      if (sl < VB) begin
        md[sl] = d[8*i +: 8];
        ma[sl] = (a + i) % MS;
        mm[sl] = (((a + i) % MS) <= ((a + len) % MS)) && (!pen || pred[sl]);
      end
    end
  endtask

  task automatic run_commit(bit wide, string tag, bit inject);
    int s = wide ? 4 : 2;
    int rexp = 0;
    bit seen = 0;
    rd_seen = 0; wr_seen = 0;
    op_start = 1; op_wide = wide;
    @(negedge clk);
    op_start = 0; commit = 1;
    for (int e = 0; e < VB; e += s) if (mm[e]) begin
      longint cur = 0, incv = 0, sum;
      for (int j = 0; j < s; j++) begin
        cur  |= longint'(emem[ma[e+j]]) << (8*j);
        incv |= longint'(md[e+j]) << (8*j);
      end
      sum = (cur + incv) & ((64'd1 << (8*s)) - 1);
      for (int j = 0; j < s; j++) begin
        emem[ma[e+j]] = 8'(sum >> (8*j));
        qa.push_back(ma[e+j]); qd.push_back(int'((sum >> (8*j)) & 255)); qt.push_back(tag);
        mm[e+j] = 0; md[e+j] = 0;
      end
      rexp += s;
    end
    for (int k = 0; k < VB; k++) mm[k] = 0;
    @(negedge clk);
    commit = 0;
    chk(busy == 1'b1, {tag, " R9 busy after commit"}, int'(busy), 1);
    if (inject) begin
      log_elem(16'h2F0, 9, 1, 3, 0, '0, 32'h55667788, 0);
      log_elem(16'h2F8, 0, 0, 1, 0, '0, 32'h00000101, 0);
    end
    for (int c = 0; c < 5000 && !seen; c++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk(seen, {tag, " R9 done seen"}, int'(seen), 1);
    @(negedge clk);
    chk(!busy && !done, {tag, " R9 done one cycle, idle after"}, int'({busy, done}), 0);
    chk(qa.size() == 0, {tag, " R6 all expected writes"}, qa.size(), 0);
    chk(rd_seen == rexp, {tag, " R5 read count"}, rd_seen, rexp);
    chk(wr_seen == rexp, {tag, " R5 write count"}, wr_seen, rexp);
    qa.delete(); qd.delete(); qt.delete();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    logic [VB-1:0] pv;
    for (int a = 0; a < MS; a++) begin
      mem[a] = 8'(a * 37 + 11);
      emem[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_en, "R1 reset outputs", int'({busy, done, mem_en}), 0);
    run_commit(1, "R1 empty log", 0);

    // R2 R6: word elements, one out of range
    log_elem(16'h100, 0, 1, 3, 0, '0, 32'h01020304, 1);
    log_elem(16'h200, 5, 1, 3, 0, '0, 32'hFFFFFFFF, 1);
    log_elem(16'h300, 40, 1, 3, 0, '0, 32'hDEADBEEF, 1);
    run_commit(1, "R2 word mapping", 0);

    // R6: halfword carries and overlap
    log_elem(16'h050, 0, 0, 1, 0, '0, 32'h0000FFFF, 1);
    log_elem(16'h3FE, 63, 0, 1, 0, '0, 32'h00001234, 1);
    log_elem(16'h050, 7, 0, 1, 0, '0, 32'h00000101, 1);
    run_commit(0, "R6 halfword overlap", 0);

    // R3: length bound and wrap
    log_elem(16'h120, 2, 1, 0, 0, '0, 32'h11223344, 1);
    log_elem(16'h3FE, 4, 1, 16'h3FF, 0, '0, 32'hA5A5A5A5, 1);
    run_commit(1, "R3 first byte invalid skipped", 0);
    log_elem(16'h3FE, 4, 1, 16'h3FF, 0, '0, 32'hA5A5A5A5, 1);
    run_commit(0, "R3 wrapped half committed", 0);

    // R4: predicates
    pv = '0;
    pv[5] = 1; pv[6] = 1; pv[7] = 1; pv[8] = 1;
    log_elem(16'h080, 1, 1, 3, 1, pv, 32'h01010101, 1);
    log_elem(16'h090, 2, 1, 3, 1, pv, 32'h7F7F7F7F, 1);
    log_elem(16'h0A0, 3, 1, 3, 0, '0, 32'h00000080, 1);
    run_commit(1, "R4 predicate lanes", 1);

    // R10: entries injected during the previous commit must not appear
    run_commit(1, "R10 ignored while busy", 0);

    // R11: clear drops staged entries
    log_elem(16'h140, 3, 0, 1, 0, '0, 32'h00004242, 1);
    clr = 1;
    @(negedge clk);
    clr = 0;
    for (int k = 0; k < VB; k++) mm[k] = 0;
    run_commit(0, "R11 clear", 0);

    // R9: commit without start ignored
    log_elem(16'h160, 1, 0, 1, 0, '0, 32'h00000203, 1);
    commit = 1;
    @(negedge clk);
    commit = 0;
    for (int c = 0; c < 10; c++) @(negedge clk);
    chk(!busy && !mem_en, "R9 unarmed commit ignored", int'({busy, mem_en}), 0);
    run_commit(0, "R9 armed commit", 0);

    // R8: nothing left after commit
    run_commit(0, "R8 log empty after commit", 0);

    for (int a = 0; a < MS; a++)
      if (mem[a] != emem[a]) chk(0, "R6 final memory", int'(mem[a]), int'(emem[a]));
    chk(1, "R6 final memory scan", 0, 0);
    summary();
    $finish;
  end
endmodule